// File: doc/BRIEF.md
# Step Attenuator Mode Control Logic

This block is the control core of a 7-bit digital step attenuator. It keeps the attenuation state that drives the RF switch network and chooses where that state comes from. A mode input picks one of two sources. The first is the parallel control pins. In parallel mode they can be transparent (direct) or latched. The second is a 7-bit word from a serial receiver, which the block takes when the receiver raises a load strobe.

After power-on reset the block forces maximum attenuation (31.75 dB). It holds that value for a programmable number of clock ticks, which stands in for the preset delay of direct mode. Once that window closes, a direct-mode configuration takes the preset pin value. Latched and serial configurations keep maximum attenuation until a new value is captured.

Top module: `step_atten_ctrl`

## Requirements
- R1: While the synchronous reset is high, and on the cycle after it, `atten_code` is 7'b1111111 (31.75 dB).
- R2: For the first `PRESET_TICKS` clock edges after reset is released, `atten_code` stays 7'b1111111 whatever the other inputs do.
- R3: The code is attenuation times four. Bit 6 weighs 16 dB, bit 5 8 dB, bit 4 4 dB, bit 3 2 dB, bit 2 1 dB, bit 1 0.5 dB and bit 0 0.25 dB. A pin pattern reaches `atten_code` with its bit order unchanged (for example, 7'd73 is 18.25 dB).
- R4: With `ser_sel`=0, `latch_en`=1 and the window closed, `atten_code` equals the `par_code` value sampled one clock earlier.
- R5: With `ser_sel`=0 and `latch_en`=0, `atten_code` holds its value while `par_code` changes.
- R6: A `latch_en` pulse that goes high then low keeps the `par_code` value that was present during the last high cycle.
- R7: With `ser_sel`=1 and `ser_load`=1 (window closed), `atten_code` takes `ser_code` one clock later.
- R8: With `ser_sel`=1, changes on `par_code` and `latch_en` do not affect `atten_code`.
- R9: With `ser_sel`=0, `ser_load` and `ser_code` do not affect `atten_code`.
- R10: If no capture happens after the window, `atten_code` stays 7'b1111111 in latched mode (`latch_en` low) and in serial mode (no load).
- R11: Moving from serial mode to parallel mode with `latch_en` low keeps the serially loaded code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ser_sel | input | 1 | 0 selects parallel control, 1 selects serial control |
| latch_en | input | 1 | Parallel latch enable; high is transparent |
| par_code | input | 7 | Parallel control pins, bit 6 = 16 dB |
| ser_code | input | 7 | Attenuation word from the serial receiver |
| ser_load | input | 1 | Strobe from the serial receiver to apply `ser_code` |
| atten_code | output | 7 | Registered attenuation state to the RF core |

## Verification
The hardest case to reach is the edge where the preset window closes. Both the cycle before the first direct-mode update and the cycle of that update have to be observed exactly. The bench shortens the window with a small `PRESET_TICKS` and holds a non-maximum preset on the pins from reset release. It then checks every cycle of the window and the first cycle after it. It also repeats the reset in latched and serial configurations to show that no update occurs at all in those cases.

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int CODE_W       = 7,
  parameter int PRESET_TICKS = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_sel,
  input  logic              latch_en,
  input  logic [CODE_W-1:0] par_code,
  input  logic [CODE_W-1:0] ser_code,
  input  logic              ser_load,
  output logic [CODE_W-1:0] atten_code
);

  localparam int CNT_W = $clog2(PRESET_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESET_TICKS);
  localparam logic [CODE_W-1:0] MAX_CODE = '1;

  logic [CNT_W-1:0]  boot_cnt;
  logic [CODE_W-1:0] state_q;
  logic              win_open;
  logic              par_take;
  logic              ser_take;

  assign win_open = boot_cnt != LAST;
  assign par_take = !ser_sel && latch_en;
  assign ser_take = ser_sel && ser_load;
  assign atten_code = state_q;

  always_ff @(posedge clk) begin
    if (rst)
      boot_cnt <= '0;
    else if (win_open)
      boot_cnt <= boot_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || win_open)
      state_q <= MAX_CODE;
    else if (par_take)
      state_q <= par_code;
    else if (ser_take)
      state_q <= ser_code;
  end

  a_r2_window_max: assert property (@(posedge clk) disable iff (rst)
    win_open |=> atten_code == MAX_CODE);

  a_r4_direct_follow: assert property (@(posedge clk) disable iff (rst)
    (!win_open && !ser_sel && latch_en) |=> atten_code == $past(par_code));

  a_r5_hold_when_low: assert property (@(posedge clk) disable iff (rst)
    (!win_open && !ser_sel && !latch_en) |=> $stable(atten_code));

  a_r7_serial_load: assert property (@(posedge clk) disable iff (rst)
    (!win_open && ser_sel && ser_load) |=> atten_code == $past(ser_code));

  a_r8_serial_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (ser_sel && !ser_load) |=> $stable(atten_code) || atten_code == MAX_CODE);

endmodule

// File: tb/test_step_atten_ctrl.sv
module test_step_atten_ctrl;
  localparam int TICKS = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_sel = 1'b0;
  logic       latch_en = 1'b0;
  logic [6:0] par_code = '0;
  logic [6:0] ser_code = '0;
  logic       ser_load = 1'b0;
  logic [6:0] atten_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  step_atten_ctrl #(.CODE_W(7), .PRESET_TICKS(TICKS)) i_step_atten_ctrl (
    .clk(clk), .rst(rst), .ser_sel(ser_sel), .latch_en(latch_en),
    .par_code(par_code), .ser_code(ser_code), .ser_load(ser_load),
    .atten_code(atten_code)
  );

  task automatic chk(input string req, input logic [6:0] exp);
    checks++;
    if (atten_code !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, atten_code, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic sel, input logic le, input logic [6:0] pins);
    rst = 1'b1; ser_sel = sel; latch_en = le; par_code = pins; ser_load = 1'b0;
    step(); step();
    chk("R1", 7'd127);
    rst = 1'b0;
    for (int k = 1; k <= TICKS; k++) begin
      step();
      chk("R2", 7'd127);
    end
  endtask

  initial begin
    step();
    // R1/R2/R3: direct mode with preset 73 (18.25 dB)
    do_reset(1'b0, 1'b1, 7'd73);
    step();
    chk("R3 first update after window", 7'd73);

    // R4 direct sweep over all codes
    for (int v = 0; v < 128; v++) begin
      par_code = 7'(v);
      step();
      chk("R4", 7'(v));
    end

    // R5/R6 latched sweep
    for (int v = 0; v < 128; v++) begin
      latch_en = 1'b0;
      par_code = 7'(v);
      step();
      chk("R5", 7'(v == 0 ? 127 : v - 1));
      latch_en = 1'b1;
      step();
      latch_en = 1'b0;
      par_code = ~7'(v);
      step();
      chk("R6", 7'(v));
    end

    // R9: serial inputs ignored in parallel mode
    ser_code = 7'd5; ser_load = 1'b1;
    step(); step();
    chk("R9", 7'd127);
    ser_load = 1'b0;

    // R7/R8 serial sweep
    ser_sel = 1'b1;
    for (int v = 0; v < 128; v++) begin
      ser_code = 7'(v); ser_load = 1'b1;
      step();
      chk("R7", 7'(v));
      ser_load = 1'b0; ser_code = ~7'(v);
      par_code = 7'(v ^ 7'h55); latch_en = 1'b1;
      step();
      latch_en = 1'b0;
      step();
      chk("R8", 7'(v));
    end

    // R11: back to parallel with latch_en low
    ser_code = 7'd42; ser_load = 1'b1;
    step();
    ser_load = 1'b0; ser_sel = 1'b0; latch_en = 1'b0; par_code = 7'd3;
    step(); step();
    chk("R11", 7'd42);

    // R10: latched mode after reset, no capture
    do_reset(1'b0, 1'b0, 7'd9);
    repeat (5) step();
    chk("R10 latched", 7'd127);

    // R10: serial mode after reset, no load
    do_reset(1'b1, 1'b0, 7'd9);
    repeat (5) step();
    chk("R10 serial", 7'd127);
    ser_code = 7'd17; ser_load = 1'b1;
    step();
    chk("R7 after window", 7'd17);
    ser_load = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule